// File: doc/BRIEF.md
# Two-level IO page table walker

This block turns a device I/O virtual address (IOVA) into a physical address. It walks a two-level page table that lives in memory. A request carries the IOVA together with read and write intent flags. The walker first picks one of up to four root tables using the top bits of the IOVA. It then makes two dependent reads of 64-bit entries: a first-level entry that points at a second-level table, and a leaf entry that gives the page frame and its permission flags.

When the walk ends, the walker returns one of two results. On success it returns the physical address together with the leaf's no-read, no-write and no-cache flags. On failure it returns a fault code instead.

Software sets up several configuration inputs and holds them steady while a walk is running:
- the granule, 4 KB or 16 KB;
- the width of the input address;
- the entry format;
- the root table bases.

In the compact entry format, the address is stored in place and reaches 36 bits. In the wide format, the address is stored shifted right by four, which gives a 42-bit physical space.

Top module: `iopt_walker`

## Requirements
- R1: One request is handled at a time. `req_ready_o` goes low at acceptance and stays low until the response is taken. While `rsp_valid_o` is high and `rsp_ready_i` is low, the response holds steady.
- R2: The number of index bits per level is b = 9 when `gran_16k_i`=0 and b = 11 when it is 1. The two indexes are:
  - first-level index L1 = (iova >> (2b+3)) masked to b bits;
  - second-level index L2 = (iova >> (b+3)) masked to b bits.

  The first read goes to root_base + 8·L1. The second read goes to table_addr + 8·L2.
- R3: The root number is (iova >> (3b+3)) masked to t bits, where t = max(0, `in_width_i` − 3b − 3), capped at 2. It selects the matching entry of `root_base_i`.
- R4: Any set IOVA bit at or above `in_width_i` gives fault code 3 (range). No memory read is made.
- R5: There is at most one outstanding memory read. The root-level entry is always read before the leaf. A walk that reaches the leaf makes exactly two reads.
- R6: Compact format (`fmt2_i`=0) decodes an entry as follows:
  - the address is entry[35:12], kept in place;
  - no-read is bit 8 and no-write is bit 7;
  - no-cache is reported as 0.
- R7: Wide format (`fmt2_i`=1) decodes an entry as follows:
  - the address is entry[37:10] shifted left by 4, giving pa[41:14];
  - no-read is bit 3, no-write is bit 2 and no-cache is bit 1.
- R8: Bit 0 of an entry is its valid flag. A first-level entry with bit 0 clear gives fault code 1 (translation) after one read. A leaf with bit 0 clear gives fault code 1 after two reads.
- R9: A request whose write flag meets a set no-write bit, or whose read flag meets a set no-read bit, gives fault code 2 (permission). A request with neither flag never gets a permission fault.
- R10: On success (code 0), the physical address is the leaf address ORed with the IOVA bits below the page size: 12 bits for a 4 KB granule, 14 bits for a 16 KB granule. The leaf flags are reported alongside it.
- R11: On any fault, `rsp_pa_o` and all three flag outputs are zero.
- R12: Out of reset, `req_ready_o`=1, `rsp_valid_o`=0 and `mem_req_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gran_16k_i | input | 1 | Granule select: 0 = 4 KB, 1 = 16 KB |
| fmt2_i | input | 1 | Entry format select: 0 = compact, 1 = wide |
| in_width_i | input | 6 | Input address width in bits |
| root_base_i | input | 4x42 | Root table base addresses |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_iova_i | input | 48 | I/O virtual address |
| req_read_i | input | 1 | Request intends to read |
| req_write_i | input | 1 | Request intends to write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_pa_o | output | 42 | Physical address |
| rsp_fault_o | output | 2 | 0 none, 1 translation, 2 permission, 3 range |
| rsp_no_read_o | output | 1 | Leaf no-read flag |
| rsp_no_write_o | output | 1 | Leaf no-write flag |
| rsp_no_cache_o | output | 1 | Leaf no-cache flag |
| mem_req_o | output | 1 | Single-cycle entry read strobe |
| mem_addr_o | output | 42 | Entry read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read entry |

## Verification
The assertions make two assumptions about the memory side:
- it returns exactly one `mem_rvalid_i` pulse for each strobe, and never returns data unprompted;
- granule, format, width and root bases stay fixed while a walk is in flight.

The stimulus keeps to both. The memory model answers each strobe after a fixed two-cycle delay. The bench changes configuration only once its expected-result queue has drained. Table and page addresses are always aligned to the active granule. `in_width_i` is chosen so that at most two root-select bits are ever needed.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int PTE_W  = 64;
  localparam int PA_W   = 42;
  localparam int OFFS_W = 14;  // widest in-page offset, 16 KB

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_PERM  = 2'd2,
    FLT_RANGE = 2'd3
  } fault_e;

  typedef struct packed {
    logic            valid;
    logic [PA_W-1:0] addr;
    logic            no_read;
    logic            no_write;
    logic            no_cache;
  } pte_t;
endpackage

// File: rtl/iopt_index.sv
module iopt_index import iopt_pkg::*; #(
  parameter int IOVA_W     = 48,
  parameter int ROOT_SEL_W = 2,
  parameter int INW_W      = 6
) (
  input  logic [IOVA_W-1:0]     iova_i,
  input  logic                  gran_16k_i,
  input  logic [INW_W-1:0]      in_width_i,
  output logic [ROOT_SEL_W-1:0] root_sel_o,
  output logic [OFFS_W-1:0]     l1_off_o,
  output logic [OFFS_W-1:0]     l2_off_o,
  output logic [OFFS_W-1:0]     page_off_o,
  output logic                  range_err_o
);
  logic [5:0]  bpl, sh_l1, sh_l2, sh_rt;
  logic [10:0] idx_mask, l1_idx, l2_idx;
  logic [ROOT_SEL_W-1:0] root_mask;
  int tbits, tbits_c;

  assign bpl      = gran_16k_i ? 6'd11 : 6'd9;
  assign sh_l2    = bpl + 6'd3;
  assign sh_l1    = {bpl[4:0], 1'b0} + 6'd3;
  assign sh_rt    = sh_l1 + bpl;
  assign idx_mask = gran_16k_i ? 11'h7ff : 11'h1ff;

  assign l1_idx   = 11'(iova_i >> sh_l1) & idx_mask;
  assign l2_idx   = 11'(iova_i >> sh_l2) & idx_mask;
  assign l1_off_o = {l1_idx, 3'b000};
  assign l2_off_o = {l2_idx, 3'b000};
  assign page_off_o = OFFS_W'(iova_i) & (gran_16k_i ? 14'h3fff : 14'h0fff);

  // root-select width shrinks as the input space shrinks
  always_comb begin
    tbits   = int'(in_width_i) - int'(sh_rt);
    tbits_c = (tbits < 0) ? 0 : ((tbits > ROOT_SEL_W) ? ROOT_SEL_W : tbits);
    root_mask = ROOT_SEL_W'((1 << tbits_c) - 1);
  end
  assign root_sel_o = ROOT_SEL_W'(iova_i >> sh_rt) & root_mask;

  assign range_err_o = (int'(in_width_i) < IOVA_W) && ((iova_i >> in_width_i) != '0);
endmodule

// File: rtl/iopt_pte_decode.sv
module iopt_pte_decode import iopt_pkg::*; (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             fmt2_i,
  output pte_t             pte_o
);
  always_comb begin
    pte_o.valid = pte_i[0];
    if (fmt2_i) begin
      pte_o.addr     = {pte_i[37:10], 14'b0};  // stored >>4
      pte_o.no_read  = pte_i[3];
      pte_o.no_write = pte_i[2];
      pte_o.no_cache = pte_i[1];
    end else begin
      pte_o.addr     = {6'b0, pte_i[35:12], 12'b0};
      pte_o.no_read  = pte_i[8];
      pte_o.no_write = pte_i[7];
      pte_o.no_cache = 1'b0;
    end
  end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker import iopt_pkg::*; #(
  parameter int IOVA_W    = 48,
  parameter int NUM_ROOTS = 4,
  localparam int ROOT_SEL_W = (NUM_ROOTS > 1) ? $clog2(NUM_ROOTS) : 1,
  localparam int INW_W      = $clog2(IOVA_W + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           gran_16k_i,
  input  logic                           fmt2_i,
  input  logic [INW_W-1:0]               in_width_i,
  input  logic [NUM_ROOTS-1:0][PA_W-1:0] root_base_i,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [IOVA_W-1:0]              req_iova_i,
  input  logic                           req_read_i,
  input  logic                           req_write_i,
  output logic                           rsp_valid_o,
  input  logic                           rsp_ready_i,
  output logic [PA_W-1:0]                rsp_pa_o,
  output logic [1:0]                     rsp_fault_o,
  output logic                           rsp_no_read_o,
  output logic                           rsp_no_write_o,
  output logic                           rsp_no_cache_o,
  output logic                           mem_req_o,
  output logic [PA_W-1:0]                mem_addr_o,
  input  logic                           mem_rvalid_i,
  input  logic [PTE_W-1:0]               mem_rdata_i
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
  } state_e;

  state_e                state_q;
  logic [IOVA_W-1:0]     iova_q;
  logic                  rd_q, wr_q;
  logic [PA_W-1:0]       tbl_q;
  logic [ROOT_SEL_W-1:0] root_sel;
  logic [OFFS_W-1:0]     l1_off, l2_off, page_off;
  logic                  range_err;
  pte_t                  ent;
  logic                  perm_bad;

  iopt_index #(
    .IOVA_W(IOVA_W), .ROOT_SEL_W(ROOT_SEL_W), .INW_W(INW_W)
  ) u_index (
    .iova_i(iova_q), .gran_16k_i(gran_16k_i), .in_width_i(in_width_i),
    .root_sel_o(root_sel), .l1_off_o(l1_off), .l2_off_o(l2_off),
    .page_off_o(page_off), .range_err_o(range_err)
  );

  iopt_pte_decode u_dec (.pte_i(mem_rdata_i), .fmt2_i(fmt2_i), .pte_o(ent));

  assign perm_bad    = (wr_q && ent.no_write) || (rd_q && ent.no_read);
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign mem_req_o   = ((state_q == ST_L1_REQ) && !range_err) || (state_q == ST_L2_REQ);
  assign mem_addr_o  = (state_q == ST_L2_REQ) ? tbl_q + PA_W'(l2_off)
                                              : root_base_i[root_sel] + PA_W'(l1_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      iova_q         <= '0;
      rd_q           <= 1'b0;
      wr_q           <= 1'b0;
      tbl_q          <= '0;
      rsp_pa_o       <= '0;
      rsp_fault_o    <= FLT_NONE;
      rsp_no_read_o  <= 1'b0;
      rsp_no_write_o <= 1'b0;
      rsp_no_cache_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          iova_q         <= req_iova_i;
          rd_q           <= req_read_i;
          wr_q           <= req_write_i;
          rsp_pa_o       <= '0;
          rsp_fault_o    <= FLT_NONE;
          rsp_no_read_o  <= 1'b0;
          rsp_no_write_o <= 1'b0;
          rsp_no_cache_o <= 1'b0;
          state_q        <= ST_L1_REQ;
        end
        ST_L1_REQ: begin
          if (range_err) begin
            rsp_fault_o <= FLT_RANGE;
            state_q     <= ST_RESP;
          end else begin
            state_q     <= ST_L1_WAIT;
          end
        end
        ST_L1_WAIT: if (mem_rvalid_i) begin
          if (ent.valid) begin
            tbl_q   <= ent.addr;
            state_q <= ST_L2_REQ;
          end else begin
            rsp_fault_o <= FLT_XLATE;
            state_q     <= ST_RESP;
          end
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          state_q <= ST_RESP;
          if (!ent.valid) begin
            rsp_fault_o <= FLT_XLATE;
          end else if (perm_bad) begin
            rsp_fault_o <= FLT_PERM;
          end else begin
            rsp_pa_o       <= ent.addr | PA_W'(page_off);
            rsp_no_read_o  <= ent.no_read;
            rsp_no_write_o <= ent.no_write;
            rsp_no_cache_o <= ent.no_cache;
          end
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk import iopt_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            req_read_i,
  input logic            req_write_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [1:0]      rsp_fault_o,
  input logic            rsp_no_read_o,
  input logic            rsp_no_write_o,
  input logic            rsp_no_cache_o,
  input logic            mem_req_o,
  input logic            mem_rvalid_i
);
  logic       outstanding;
  logic [1:0] nreads;
  logic       rd_l, wr_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outstanding <= 1'b0;
      nreads      <= '0;
      rd_l        <= 1'b0;
      wr_l        <= 1'b0;
    end else begin
      if (mem_req_o) outstanding <= 1'b1;
      else if (mem_rvalid_i) outstanding <= 1'b0;
      if (req_valid_i && req_ready_o) begin
        nreads <= '0;
        rd_l   <= req_read_i;
        wr_l   <= req_write_i;
      end else if (mem_req_o && nreads != 2'd3) begin
        nreads <= nreads + 2'd1;
      end
    end
  end

  a_r1_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  a_r1_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o));

  a_r5_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outstanding);

  a_r4_range_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o == 2'd3 |-> nreads == 2'd0);

  a_r5_full_walk_two_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o == 2'd0 || rsp_fault_o == 2'd2) |-> nreads == 2'd2);

  a_r8_xlate_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o == 2'd1 |-> nreads == 2'd1 || nreads == 2'd2);

  a_r9_perm_honoured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o == 2'd0 |-> !(wr_l && rsp_no_write_o) && !(rd_l && rsp_no_read_o));

  a_r11_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'd0 |->
      rsp_pa_o == '0 && !rsp_no_read_o && !rsp_no_write_o && !rsp_no_cache_o);
endmodule

bind iopt_walker iopt_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_read_i(req_read_i), .req_write_i(req_write_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_pa_o(rsp_pa_o), .rsp_fault_o(rsp_fault_o),
  .rsp_no_read_o(rsp_no_read_o), .rsp_no_write_o(rsp_no_write_o),
  .rsp_no_cache_o(rsp_no_cache_o),
  .mem_req_o(mem_req_o), .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/iopt_walker_tb.sv
module iopt_walker_tb;
  localparam int IOVA_W = 48;
  localparam int PA_W   = 42;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              gran_16k_i = 1'b0, fmt2_i = 1'b0;
  logic [5:0]        in_width_i = 6'd32;
  logic [3:0][PA_W-1:0] root_base_i;
  logic              req_valid_i = 1'b0, req_ready_o;
  logic [IOVA_W-1:0] req_iova_i = '0;
  logic              req_read_i = 1'b0, req_write_i = 1'b0;
  logic              rsp_valid_o, rsp_ready_i = 1'b0;
  logic [PA_W-1:0]   rsp_pa_o;
  logic [1:0]        rsp_fault_o;
  logic              rsp_no_read_o, rsp_no_write_o, rsp_no_cache_o;
  logic              mem_req_o;
  logic [PA_W-1:0]   mem_addr_o;
  logic              mem_rvalid_i = 1'b0;
  logic [63:0]       mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  iopt_walker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .gran_16k_i(gran_16k_i), .fmt2_i(fmt2_i),
    .in_width_i(in_width_i), .root_base_i(root_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_iova_i(req_iova_i),
    .req_read_i(req_read_i), .req_write_i(req_write_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_pa_o(rsp_pa_o),
    .rsp_fault_o(rsp_fault_o), .rsp_no_read_o(rsp_no_read_o),
    .rsp_no_write_o(rsp_no_write_o), .rsp_no_cache_o(rsp_no_cache_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  typedef struct {
    logic [PA_W-1:0] pa;
    logic [1:0]      flt;
    logic            nr, nw, nc;
    int              nrd;
    string           tag;
  } exp_t;

  exp_t            exp_q[$];
  logic [PA_W-1:0] addr_q[$];
  string           atag_q[$];
  logic [63:0]     mem [logic [PA_W-1:0]];
  int n_tests = 0, n_fail = 0, rd_cnt = 0, lat = 0, rdy_ctr = 0;
  logic [63:0] rd_data = '0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] enc(input logic [PA_W-1:0] a);
    if (fmt2_i) return ({22'b0, a} >> 4) & 64'h0000_003f_ffff_fc00;
    return {22'b0, a} & 64'h0000_000f_ffff_f000;
  endfunction

  function automatic logic [PA_W-1:0] dec(input logic [63:0] e);
    if (fmt2_i) return PA_W'(((e >> 10) & 64'h0fff_ffff) << 14);
    return PA_W'(e & 64'h0000_000f_ffff_f000);
  endfunction

  function automatic logic [63:0] rdmem(input logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // expectation built from the requirement formulas, then request driven
  task automatic send(input logic [IOVA_W-1:0] iova, input bit rd, input bit wr, input string tag);
    exp_t e;
    int b, t;
    logic [63:0] e1, e2;
    logic [PA_W-1:0] a1, a2;
    logic [IOVA_W-1:0] l1, l2, rt;
    b = gran_16k_i ? 11 : 9;
    e.pa = '0; e.flt = 2'd0; e.nr = 0; e.nw = 0; e.nc = 0; e.nrd = 0; e.tag = tag;
    if (int'(in_width_i) < IOVA_W && (iova >> in_width_i) != 0) begin
      e.flt = 2'd3;
    end else begin
      t = int'(in_width_i) - 3*b - 3;
      if (t < 0) t = 0;
      if (t > 2) t = 2;
      rt = (iova >> (3*b + 3)) & ((48'd1 << t) - 1);
      l1 = (iova >> (2*b + 3)) & ((48'd1 << b) - 1);
      l2 = (iova >> (b + 3)) & ((48'd1 << b) - 1);
      a1 = root_base_i[rt[1:0]] + PA_W'(l1 * 8);
      addr_q.push_back(a1); atag_q.push_back({tag, " R2 R3 first read"});
      e.nrd = 1;
      e1 = rdmem(a1);
      if (!e1[0]) e.flt = 2'd1;
      else begin
        a2 = dec(e1) + PA_W'(l2 * 8);
        addr_q.push_back(a2); atag_q.push_back({tag, " R2 leaf read"});
        e.nrd = 2;
        e2 = rdmem(a2);
        if (!e2[0]) e.flt = 2'd1;
        else begin
          e.nr = fmt2_i ? e2[3] : e2[8];
          e.nw = fmt2_i ? e2[2] : e2[7];
          e.nc = fmt2_i ? e2[1] : 1'b0;
          if ((wr && e.nw) || (rd && e.nr)) begin
            e.flt = 2'd2; e.nr = 0; e.nw = 0; e.nc = 0;
          end else begin
            e.pa = dec(e2) | PA_W'(iova & (gran_16k_i ? 48'h3fff : 48'h0fff));
          end
        end
      end
    end
    exp_q.push_back(e);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_iova_i = iova; req_read_i = rd; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic map_l1(input int r, input int b, input int idx, input logic [PA_W-1:0] tbl);
    mem[root_base_i[r] + PA_W'(idx * 8)] = enc(tbl) | 64'h1;
    if (b == 0) ;
  endtask

  task automatic map_l2(input logic [PA_W-1:0] tbl, input int idx, input logic [PA_W-1:0] pg, input logic [63:0] fl);
    mem[tbl + PA_W'(idx * 8)] = enc(pg) | fl | 64'h1;
  endtask

  function automatic logic [IOVA_W-1:0] mk(input int b, input int r, input int i1, input int i2, input int off);
    return (IOVA_W'(r) << (3*b + 3)) | (IOVA_W'(i1) << (2*b + 3)) | (IOVA_W'(i2) << (b + 3)) | IOVA_W'(off);
  endfunction

  // memory model: two-cycle read latency, checks every read address
  always @(negedge clk_i) begin
    if (mem_rvalid_i) mem_rvalid_i = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = rd_data; end
    end
    if (mem_req_o && rst_ni) begin
      rd_cnt++;
      if (addr_q.size() == 0) check(0, "R5 unexpected read", 64'(mem_addr_o), 64'h0);
      else begin
        logic [PA_W-1:0] ea;
        string et;
        ea = addr_q.pop_front(); et = atag_q.pop_front();
        check(mem_addr_o == ea, et, 64'(mem_addr_o), 64'(ea));
      end
      rd_data = rdmem(mem_addr_o);
      lat = 2;
    end
  end

  // monitor: stalls the response on a pattern, compares on handshake
  always @(negedge clk_i) begin
    if (rst_ni) begin
      rdy_ctr++;
      rsp_ready_i = (rdy_ctr % 3) != 0;
      if (rsp_valid_o && rsp_ready_i) begin
        if (exp_q.size() == 0) check(0, "R1 unexpected response", 64'(rsp_pa_o), 64'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_fault_o == e.flt, {e.tag, " fault"}, 64'(rsp_fault_o), 64'(e.flt));
          check(rsp_pa_o == e.pa, {e.tag, " R10 R11 pa"}, 64'(rsp_pa_o), 64'(e.pa));
          check({rsp_no_read_o, rsp_no_write_o, rsp_no_cache_o} == {e.nr, e.nw, e.nc},
                {e.tag, " R6 R7 flags"}, 64'({rsp_no_read_o, rsp_no_write_o, rsp_no_cache_o}),
                64'({e.nr, e.nw, e.nc}));
          check(rd_cnt == e.nrd, {e.tag, " R5 read count"}, 64'(rd_cnt), 64'(e.nrd));
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [PA_W-1:0] t1, t2, t3, pg;
    for (int k = 0; k < 4; k++) root_base_i[k] = 42'h10_0000 + PA_W'(k) * 42'h1_0000;
    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1, "R12 ready at reset", 64'(req_ready_o), 64'h1);
    check(rsp_valid_o == 1'b0, "R12 rsp_valid at reset", 64'(rsp_valid_o), 64'h0);
    check(mem_req_o == 1'b0, "R12 mem_req at reset", 64'(mem_req_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // compact format, 4 KB, 32-bit input: two root-select bits
    fmt2_i = 0; gran_16k_i = 0; in_width_i = 6'd32;
    t1 = 42'h20_0000; t2 = 42'h21_0000; pg = 42'h9_8765_4000;
    map_l1(2, 9, 5, t1);
    map_l1(3, 9, 5, t2);
    map_l2(t1, 7, pg, 64'h0);
    map_l2(t1, 8, 42'h1_2345_6000, 64'h80);   // no-write bit 7
    map_l2(t1, 9, 42'h5_5555_5000, 64'h100);  // no-read bit 8
    map_l2(t2, 7, 42'h0_0abc_d000, 64'h0);
    send(mk(9, 2, 5, 7, 12'habc), 1, 1, "R3 R10 fmt1 ok");
    send(mk(9, 3, 5, 7, 12'h001), 1, 0, "R3 root3");
    send(mk(9, 2, 5, 8, 12'h010), 0, 1, "R9 write vs no-write");
    send(mk(9, 2, 5, 8, 12'h020), 1, 0, "R6 read with no-write flag");
    send(mk(9, 2, 5, 9, 12'h030), 1, 0, "R9 read vs no-read");
    send(mk(9, 2, 5, 9, 12'hfff), 0, 0, "R9 no intent");
    send(mk(9, 2, 6, 7, 12'h000), 1, 0, "R8 missing first level");
    send(mk(9, 2, 5, 10, 12'h000), 1, 0, "R8 missing leaf");
    send(48'h1_0000_0000, 1, 0, "R4 range bit32");
    send(48'h8000_0000_0000, 1, 0, "R4 range bit47");
    send(mk(9, 2, 5, 7, 12'h123), 1, 1, "R1 back to back");
    drain();

    // wide format, 16 KB, 38-bit input
    fmt2_i = 1; gran_16k_i = 1; in_width_i = 6'd38;
    t3 = 42'h200_0030_0000;
    map_l1(1, 11, 3, t3);
    map_l1(0, 11, 4, 42'h40_0000);
    map_l2(t3, 100, 42'h2ab_cdef_c000, 64'h2);  // no-cache bit 1
    map_l2(t3, 101, 42'h001_0000_4000, 64'h8);  // no-read bit 3
    map_l2(t3, 102, 42'h001_0000_8000, 64'h4);  // no-write bit 2
    send(mk(11, 1, 3, 100, 14'h1234), 1, 1, "R7 R10 fmt2 ok");
    send(mk(11, 1, 3, 101, 14'h0), 1, 0, "R7 R9 no-read");
    send(mk(11, 1, 3, 102, 14'h0), 0, 1, "R7 R9 no-write");
    send(mk(11, 1, 3, 102, 14'h3fff), 1, 0, "R7 read ok with no-write");
    send(mk(11, 0, 4, 1, 14'h0), 1, 0, "R8 fmt2 missing leaf");
    send(48'h40_0000_0000, 1, 0, "R4 range bit38");
    drain();

    // compact format, 16 KB, 37-bit input: one root-select bit
    fmt2_i = 0; gran_16k_i = 1; in_width_i = 6'd37;
    map_l1(1, 11, 2, 42'h50_0000);
    map_l2(42'h50_0000, 3, 42'h7_0000_c000, 64'h0);
    send(mk(11, 1, 2, 3, 14'h2222), 1, 0, "R2 R3 fmt1 16k");
    send(48'h20_0000_0000, 1, 0, "R4 range bit37");
    drain();

    check(addr_q.size() == 0, "R5 reads outstanding at end", 64'(addr_q.size()), 64'h0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule